// File: doc/BRIEF.md
# Bit Field Extract Unit

This block is one slice of an integer execution pipeline. Each accepted operation pulls a contiguous run of bits out of a source operand and places it at the bottom of the result, with zeros above it. The start position and the field length both come from one packed control word. The operand size is 32 or 64 bits. A field that runs past the top of the operand is cut short at the operand's highest bit, not cleared. The unit also produces the zero, carry and overflow flags for the operation.

The same issue cycle checks the operation for an undefined-opcode condition. A faulting operation produces only a fault pulse, and the architectural outputs keep their old values. A small three-state sequencer records what the previous cycle delivered: `ST_IDLE` (nothing), `ST_RESULT` (a result with flags) or `ST_FAULT` (a fault indication). It moves as follows:

- Any state goes to `ST_RESULT` on a valid, non-faulting input.
- Any state goes to `ST_FAULT` on a valid, faulting input.
- Any state goes to `ST_IDLE` when no input is valid.
- Reset forces `ST_IDLE`.

Top module: `bitfield_extract_unit`

## Requirements
- R1: The start position is taken from control bits 7:0 and the length from control bits 15:8, both as unsigned values. Control bits 63:16 have no effect on any output.
- R2: A length of zero gives an all-zero result.
- R3: A start at or above the operand size (32 or 64) gives an all-zero result.
- R4: When start plus length exceeds the operand size, the result holds source bits from the start position up to bit operand size minus one, right-justified, and zero above them.
- R5: Result bit i equals source bit start+i for every i below the length that stays inside the operand. Every result bit at position length or above is zero.
- R6: `flag_zero` is 1 exactly when the delivered result is zero. `flag_carry` and `flag_overflow` are always 0.
- R7: In 32-bit operand size, only source bits 31:0 take part, and result bits 63:32 are zero.
- R8: `undef_fault` pulses one cycle after a valid input that has `vlen_bit` = 1, or that has `wide_op` = 1 with `long_mode` = 0. For such an input `out_valid` stays 0.
- R9: `out_valid` rises exactly one cycle after a valid, non-faulting input. Synchronous active-high reset clears `out_valid`, `undef_fault`, the result and the flags.
- R10: Lengths up to 255 never wrap around. They saturate to the bits remaining in the operand.
- R11: After a faulting input, or a cycle with no valid input, the result and the flags keep their previous values.
- R12: The operand size is 64 bits only when both `wide_op` and `long_mode` are 1. Otherwise it is 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| src_data | input | 64 | Source operand |
| ctrl_word | input | 64 | Control word: start in bits 7:0, length in bits 15:8 |
| wide_op | input | 1 | 64-bit operand size requested |
| long_mode | input | 1 | Core is in 64-bit mode |
| vlen_bit | input | 1 | Vector-length bit from the prefix; must be 0 |
| out_valid | output | 1 | Result and flags delivered this cycle |
| result | output | 64 | Extracted field, zero-extended |
| flag_zero | output | 1 | Result is zero |
| flag_carry | output | 1 | Carry flag, always 0 |
| flag_overflow | output | 1 | Overflow flag, always 0 |
| undef_fault | output | 1 | Undefined-opcode indication |

## Verification
Every output of this unit is due one clock edge after the input that causes it: the result, the three flags, `out_valid` and `undef_fault`. The bench drives inputs on the falling edge and works out the expected registered state for the coming rising edge. On the next falling edge it compares every output against that state. Cycles with no valid input and faulting cycles are compared the same way, so a value that should be held is checked in the very cycle where it would otherwise change.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    localparam int BFX_DATA_W   = 64;
    localparam int BFX_NARROW_W = 32;
    localparam int BFX_FIELD_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } bfx_state_e;

    typedef struct packed {
        logic zf;
        logic cf;
        logic of;
    } bfx_flags_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode #(
    parameter int FIELD_W = bfx_pkg::BFX_FIELD_W
) (
    input  logic [2*FIELD_W-1:0] ctrl_lo,
    input  logic                 wide_op,
    input  logic                 long_mode,
    input  logic                 vlen_bit,
    output logic [FIELD_W-1:0]   start_pos,
    output logic [FIELD_W-1:0]   field_len,
    output logic                 op_wide,
    output logic                 fault
);
    always_comb begin
        start_pos = ctrl_lo[FIELD_W-1:0];
        field_len = ctrl_lo[2*FIELD_W-1:FIELD_W];
        op_wide   = wide_op && long_mode;
        fault     = vlen_bit || (wide_op && !long_mode);
    end
endmodule

// File: rtl/bfx_extract_core.sv
module bfx_extract_core #(
    parameter int DATA_W   = bfx_pkg::BFX_DATA_W,
    parameter int NARROW_W = bfx_pkg::BFX_NARROW_W,
    parameter int FIELD_W  = bfx_pkg::BFX_FIELD_W
) (
    input  logic [DATA_W-1:0]  src_data,
    input  logic [FIELD_W-1:0] start_pos,
    input  logic [FIELD_W-1:0] field_len,
    input  logic               op_wide,
    output logic [DATA_W-1:0]  field_out
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int CMP_W = FIELD_W + 1;

    logic [DATA_W-1:0] src_eff;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] len_mask;
    logic [CMP_W-1:0]  op_bits;
    logic              start_oob;

    // Narrow mode: upper source bits never reach the shifter.
    always_comb begin
        src_eff = src_data;
        if (!op_wide) begin
            src_eff[DATA_W-1:NARROW_W] = '0;
        end
    end

    assign op_bits   = op_wide ? CMP_W'(DATA_W) : CMP_W'(NARROW_W);
    assign start_oob = ({1'b0, start_pos} >= op_bits);
    assign shifted   = src_eff >> start_pos[SH_W-1:0];

    // Per-bit compare keeps lengths up to 2**FIELD_W-1 from wrapping.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign len_mask[g] = ({1'b0, field_len} > CMP_W'(g));
    end

    assign field_out = start_oob ? '0 : (shifted & len_mask);
endmodule

// File: rtl/bfx_seq.sv
module bfx_seq #(
    parameter int DATA_W = bfx_pkg::BFX_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              fault_in,
    input  logic [DATA_W-1:0] field_in,
    output logic              out_valid,
    output logic              undef_fault,
    output logic [DATA_W-1:0] result,
    output bfx_pkg::bfx_flags_t flags
);
    import bfx_pkg::*;

    bfx_state_e state_q, state_d;
    logic [DATA_W-1:0] result_q;
    bfx_flags_t        flags_q;

    always_comb begin
        if (!in_valid) begin
            state_d = ST_IDLE;
        end else if (fault_in) begin
            state_d = ST_FAULT;
        end else begin
            state_d = ST_RESULT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
        end else if (state_d == ST_RESULT) begin
            result_q   <= field_in;
            flags_q.zf <= (field_in == '0);
            flags_q.cf <= 1'b0;
            flags_q.of <= 1'b0;
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        undef_fault = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: out_valid   = 1'b1;
            ST_FAULT:  undef_fault = 1'b1;
            default:   ;
        endcase
        result = result_q;
        flags  = flags_q;
    end

    // R9: result delivered one cycle after a good input
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && !fault_in && !rst) |-> out_valid);
    // R8: faults never deliver a result
    a_r8_fault_no_valid: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && fault_in && !rst) |-> (undef_fault && !out_valid));
    // R11: faulting or idle cycles hold the architectural outputs
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(result) && $stable(flags)));
    // R6: carry and overflow are always clear
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !flags.cf && !flags.of);
endmodule

// File: rtl/bitfield_extract_unit.sv
module bitfield_extract_unit #(
    parameter int DATA_W   = bfx_pkg::BFX_DATA_W,
    parameter int NARROW_W = bfx_pkg::BFX_NARROW_W,
    parameter int FIELD_W  = bfx_pkg::BFX_FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic              wide_op,
    input  logic              long_mode,
    input  logic              vlen_bit,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_zero,
    output logic              flag_carry,
    output logic              flag_overflow,
    output logic              undef_fault
);
    localparam int CTRL_USED = 2 * FIELD_W;

    logic [FIELD_W-1:0] start_pos;
    logic [FIELD_W-1:0] field_len;
    logic               op_wide;
    logic               fault;
    logic [DATA_W-1:0]  field;
    bfx_pkg::bfx_flags_t flags;
    logic               unused_ctrl_hi;

    assign unused_ctrl_hi = ^ctrl_word[DATA_W-1:CTRL_USED];

    bfx_decode #(.FIELD_W(FIELD_W)) decode_i (
        .ctrl_lo   (ctrl_word[CTRL_USED-1:0]),
        .wide_op   (wide_op),
        .long_mode (long_mode),
        .vlen_bit  (vlen_bit),
        .start_pos (start_pos),
        .field_len (field_len),
        .op_wide   (op_wide),
        .fault     (fault)
    );

    bfx_extract_core #(
        .DATA_W(DATA_W), .NARROW_W(NARROW_W), .FIELD_W(FIELD_W)
    ) core_i (
        .src_data  (src_data),
        .start_pos (start_pos),
        .field_len (field_len),
        .op_wide   (op_wide),
        .field_out (field)
    );

    bfx_seq #(.DATA_W(DATA_W)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .fault_in    (fault),
        .field_in    (field),
        .out_valid   (out_valid),
        .undef_fault (undef_fault),
        .result      (result),
        .flags       (flags)
    );

    assign flag_zero     = flags.zf;
    assign flag_carry    = flags.cf;
    assign flag_overflow = flags.of;

    // R7: narrow operations leave the upper half clear
    a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && !rst && !vlen_bit && !wide_op) |-> (result[DATA_W-1:NARROW_W] == '0));
    // R2: zero length yields a zero result with the zero flag set
    a_r2_len_zero: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && !rst && !fault && ctrl_word[CTRL_USED-1:FIELD_W] == '0)
        |-> (result == '0 && flag_zero));
    // R6: the zero flag follows the delivered result
    a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_zero == (result == '0)));
    // R8: a set vector-length bit always faults
    a_r8_vlen_fault: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && !rst && vlen_bit) |-> undef_fault);
endmodule

// File: tb/bitfield_extract_unit_tb_top.sv
module bitfield_extract_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] src_data;
    logic [63:0] ctrl_word;
    logic        wide_op, long_mode, vlen_bit;
    logic        out_valid, flag_zero, flag_carry, flag_overflow, undef_fault;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [63:0] exp_res;
    logic        exp_zf, exp_valid, exp_fault;

    always #4 clk = ~clk;   // 125 MHz

    bitfield_extract_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_data(src_data),
        .ctrl_word(ctrl_word), .wide_op(wide_op), .long_mode(long_mode),
        .vlen_bit(vlen_bit), .out_valid(out_valid), .result(result),
        .flag_zero(flag_zero), .flag_carry(flag_carry),
        .flag_overflow(flag_overflow), .undef_fault(undef_fault)
    );

    function automatic logic [63:0] ref_extract(logic [63:0] s, logic [63:0] c, bit w64);
        int st  = int'(c[7:0]);
        int ln  = int'(c[15:8]);
        int opw = w64 ? 64 : 32;
        logic [63:0] r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < ln && (st + i) < opw) r[i] = s[st + i];
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk("R9 out_valid", 64'(out_valid), 64'(exp_valid));
        chk("R8 undef_fault", 64'(undef_fault), 64'(exp_fault));
        chk(tag, result, exp_res);
        chk("R6 flag_zero", 64'(flag_zero), 64'(exp_zf));
        chk("R6 flag_carry", 64'(flag_carry), 64'd0);
        chk("R6 flag_overflow", 64'(flag_overflow), 64'd0);
    endtask

    // Drive one cycle at the falling edge, model, compare at the next falling edge.
    task automatic step(bit v, bit w, bit lm, bit vl, logic [63:0] s, logic [63:0] c, string tag);
        bit f;
        in_valid = v; wide_op = w; long_mode = lm; vlen_bit = vl;
        src_data = s; ctrl_word = c;
        f = vl || (w && !lm);
        exp_valid = v && !f;
        exp_fault = v && f;
        if (v && !f) begin
            exp_res = ref_extract(s, c, w && lm);
            exp_zf  = (exp_res == 64'd0);
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; src_data = '0; ctrl_word = '0;
        wide_op = 1'b0; long_mode = 1'b0; vlen_bit = 1'b0;
        exp_res = '0; exp_zf = 1'b0; exp_valid = 1'b0; exp_fault = 1'b0;
        repeat (3) @(negedge clk);
        compare_all("R9 reset result");
        rst = 1'b0;

        // R1: upper control bits ignored (start 8, length 4)
        step(1, 1, 1, 0, 64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0000_0408, "R1 upper ctrl ignored");
        step(1, 1, 1, 0, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0408, "R1 same field clean ctrl");
        // R2: zero length
        step(1, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005, "R2 zero length");
        // R3: start out of range
        step(1, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0828, "R3 start 40 narrow");
        step(1, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_1040, "R3 start 64 wide");
        step(1, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_08C8, "R3 start 200");
        // R4: clipping at operand top
        step(1, 1, 1, 0, 64'hF123_4567_89AB_CDEF, 64'h0000_0000_0000_0A3C, "R4 wide clip");
        step(1, 0, 0, 0, 64'h0000_0000_D000_0000, 64'h0000_0000_0000_0A1C, "R4 narrow clip");
        // R5: placement and zero-fill
        step(1, 1, 1, 0, 64'hAAAA_AAAA_AAAA_AAAB, 64'h0000_0000_0000_0100, "R5 single bit");
        step(1, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_3F01, "R5 length 63");
        // R10: saturating long lengths
        step(1, 1, 1, 0, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_FF00, "R10 len 255 wide");
        step(1, 0, 1, 0, 64'hFFFF_FFFF_8765_4321, 64'h0000_0000_0000_FF04, "R10 len 255 narrow");
        // R7: narrow ignores upper source
        step(1, 0, 0, 0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_4000, "R7 narrow upper src");
        // R12: long mode alone stays narrow
        step(1, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_2010, "R12 narrow in long mode");
        // R6: zero result sets zero flag
        step(1, 1, 1, 0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_2000, "R6 zero result");
        step(1, 1, 1, 0, 64'h0000_0000_0000_0F00, 64'h0000_0000_0000_0408, "R6 nonzero result");
        // R8 / R11: faults hold outputs
        step(1, 1, 1, 1, 64'h1234_0000_0000_0000, 64'h0000_0000_0000_4000, "R11 hold on vlen fault");
        step(1, 1, 0, 0, 64'h1234_0000_0000_0000, 64'h0000_0000_0000_4000, "R11 hold on wide fault");
        step(1, 0, 0, 1, 64'h0, 64'h0, "R11 hold on narrow vlen fault");
        step(0, 1, 1, 0, 64'h0, 64'h0, "R11 hold when idle");
        step(1, 0, 0, 0, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0404, "R9 after fault");

        for (int k = 0; k < 500; k++) begin
            logic [63:0] s = {$urandom, $urandom};
            logic [63:0] c = {$urandom, $urandom};
            int sel = $urandom_range(0, 9);
            if (sel < 5) c[7:0] = 8'($urandom_range(0, 70));
            if (sel < 3) c[15:8] = 8'($urandom_range(0, 70));
            step($urandom_range(0, 7) != 0, 1'($urandom), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 9) == 0, s, c, "R5 random field");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule